// File: doc/BRIEF.md
# Dual Edge Capture Timer

This block timestamps level changes on two capture inputs against a free-running time base. Each of the two channels owns one register for rising-edge times and another for falling-edge times, so software can measure pulse widths and periods without polling the pins. An 8-bit window of the time base is captured, and a prescale field chooses how far up the time base that window sits.

The two channels can be joined so that channel 0 edges record a 16-bit time split over both channels' registers. An optional first-edge-hold setting freezes each capture register after its first load until software reads it. Every capture event sets its own sticky status bit. A per-event enable mask routes those bits onto a single interrupt line. Software reaches configuration, enables, status and the four capture bytes through a small byte-wide register bus with single-cycle reads.

Top module: `dual_edge_capture`

## Requirements
- R1: After reset every capture register, the configuration, the interrupt enables and the status read as zero, and irq is low.
- R2: In 8-bit mode a rising edge on channel c loads rise register c. A level change first sampled at clock edge k is loaded at edge k+2 with the time base value present at that edge. Rise registers are at address 4 for channel 0 and 6 for channel 1.
- R3: In 8-bit mode a falling edge on channel c loads fall register c with the same timing. Fall registers are at address 5 for channel 0 and 7 for channel 1. The rise register of that channel is unchanged.
- R4: Configuration bits [4:2] hold a shift p. An 8-bit capture stores time base bits [p+7:p].
- R5: Configuration bit 0 selects joined mode. A channel 0 edge then stores bits [p+7:p] in the channel 0 register of that edge type and bits [p+15:p+8] in the matching channel 1 register, both in the same cycle. Channel 1 input edges capture nothing and set no status.
- R6: Configuration bit 1 enables first-edge hold. A loaded capture register ignores further edges until it is read. A read re-arms the register that was read. In joined mode, reading a channel 0 register also re-arms its channel 1 partner.
- R7: The status register at address 2 sets bit 0 on a channel 0 rise, bit 1 on a channel 0 fall, bit 2 on a channel 1 rise and bit 3 on a channel 1 fall. The bits stay set, whether or not the capture was held.
- R8: Writing a one to a status bit clears it, and writing zero leaves it as it is. An event in the same cycle as the clear leaves the bit set.
- R9: The interrupt enable register at address 1 uses the status bit layout. irq is high exactly when some status bit and its enable are both set.
- R10: Configuration is at address 0. Reading an unused address (3) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capIn | input | 2 | Asynchronous capture inputs, bit c is channel c |
| timeBase | input | TB_W (24) | Running time base |
| regSel | input | ADDR_W (3) | Register address |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (re-arms held captures) |
| wrData | input | DATA_W (8) | Write data |
| rdData | output | DATA_W (8) | Combinational read data for regSel |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same status bit in one cycle: the software clear by a one-write and the hardware set by a new capture event. The bench provokes this by driving a channel 0 rising input and timing a status write so that it is sampled on the same clock edge that records the capture. The status bit must read back as set. A companion clear with no edge in flight must empty the bit, and a write of zero must leave set bits alone.

// File: rtl/dual_cap_pkg.sv
package dual_cap_pkg;
  localparam int SLOT_NUM = 4;
  localparam int A_CFG    = 0;
  localparam int A_IEN    = 1;
  localparam int A_STAT   = 2;
  localparam int A_CAP0   = 4;

  typedef struct packed {
    logic [SLOT_NUM-1:0] load;
    logic                wide;
  } capStrobe_t;
endpackage

// File: rtl/dual_cap_ctrl.sv
module dual_cap_ctrl
  import dual_cap_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int SHIFT_W = 3,
  localparam int CFG_W  = SHIFT_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         capIn,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  regSel,
  input  logic [DATA_W-1:0]  wrData,
  output capStrobe_t         strobe,
  output logic [SHIFT_W-1:0] shift,
  output logic [CFG_W-1:0]   cfgQ,
  output logic [3:0]         ienQ,
  output logic [3:0]         statusQ,
  output logic               irq
);
  logic [1:0] syncA, syncB, lastLvl;
  logic [1:0] riseSeen, fallSeen;
  logic [SLOT_NUM-1:0] slotEdge, flagEdge, rearm, heldQ;
  logic [3:0] clrMask;
  logic wide, holdFirst;

  assign wide      = cfgQ[0];
  assign holdFirst = cfgQ[1];
  assign shift     = cfgQ[CFG_W-1:2];

  // two-stage synchronizer followed by one level register for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      lastLvl <= '0;
    end else begin
      syncA   <= capIn;
      syncB   <= syncA;
      lastLvl <= syncB;
    end
  end

  assign riseSeen = syncB & ~lastLvl;
  assign fallSeen = ~syncB & lastLvl;

  // slot order: 0 ch0 rise, 1 ch0 fall, 2 ch1 rise, 3 ch1 fall
  assign slotEdge = wide ? {fallSeen[0], riseSeen[0], fallSeen[0], riseSeen[0]}
                         : {fallSeen[1], riseSeen[1], fallSeen[0], riseSeen[0]};
  assign flagEdge = wide ? {2'b00, fallSeen[0], riseSeen[0]} : slotEdge;

  for (genvar i = 0; i < SLOT_NUM; i++) begin : g_slot
    if (i < 2) begin : g_low
      assign rearm[i] = rdEn && (regSel == ADDR_W'(A_CAP0 + i));
    end else begin : g_high
      assign rearm[i] = rdEn && (wide ? (regSel == ADDR_W'(A_CAP0 + i - 2))
                                      : (regSel == ADDR_W'(A_CAP0 + i)));
    end

    assign strobe.load[i] = slotEdge[i] && (!holdFirst || !heldQ[i] || rearm[i]);

    always_ff @(posedge clk) begin
      if (!rstN)                           heldQ[i] <= 1'b0;
      else if (strobe.load[i] && holdFirst) heldQ[i] <= 1'b1;
      else if (rearm[i] || !holdFirst)      heldQ[i] <= 1'b0;
    end
  end

  assign strobe.wide = wide;

  assign clrMask = (wrEn && regSel == ADDR_W'(A_STAT)) ? wrData[3:0] : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= '0;
      ienQ    <= '0;
      statusQ <= '0;
    end else begin
      if (wrEn && regSel == ADDR_W'(A_CFG)) cfgQ <= wrData[CFG_W-1:0];
      if (wrEn && regSel == ADDR_W'(A_IEN)) ienQ <= wrData[3:0];
      statusQ <= (statusQ & ~clrMask) | flagEdge;
    end
  end

  assign irq = |(statusQ & ienQ);

  // R8: a set status bit survives any cycle that does not clear it
  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~clrMask) != 4'b0000) |=>
      ((statusQ & $past(statusQ & ~clrMask)) == $past(statusQ & ~clrMask)));

  // R9: irq only rises after a new capture event or an enable write
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(flagEdge) != 4'b0000 || $past(wrEn && regSel == ADDR_W'(A_IEN))));

  // R5: in joined mode channel 1 status stays clear once clear
  p_wide_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wide && statusQ[3:2] == 2'b00 && !(wrEn && regSel == ADDR_W'(A_CFG))) |=>
      statusQ[3:2] == 2'b00);
endmodule

// File: rtl/dual_cap_data.sv
module dual_cap_data
  import dual_cap_pkg::*;
#(
  parameter int TB_W    = 24,
  parameter int DATA_W  = 8,
  parameter int SHIFT_W = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [TB_W-1:0]                  timeBase,
  input  capStrobe_t                       strobe,
  input  logic [SHIFT_W-1:0]               shift,
  output logic [SLOT_NUM-1:0][DATA_W-1:0]  capQ
);
  logic [TB_W-1:0]   window;
  logic [DATA_W-1:0] loByte, hiByte;

  assign window = timeBase >> shift;
  assign loByte = window[DATA_W-1:0];
  assign hiByte = window[2*DATA_W-1:DATA_W];

  for (genvar i = 0; i < SLOT_NUM; i++) begin : g_cap
    logic [DATA_W-1:0] nextVal;
    if (i < 2) begin : g_low
      assign nextVal = loByte;
    end else begin : g_high
      assign nextVal = strobe.wide ? hiByte : loByte;
    end

    always_ff @(posedge clk) begin
      if (!rstN)               capQ[i] <= '0;
      else if (strobe.load[i]) capQ[i] <= nextVal;
    end

    // R6: a register only moves when the control issued a load for it
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.load[i] |=> $stable(capQ[i]));
  end

  // R2: a channel 0 rise load stores the low slice of the time base
  p_capture_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load[0] |=> capQ[0] == $past(window[DATA_W-1:0]));

  // R5: joined mode stores the upper slice in the channel 1 rise register
  p_wide_upper_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wide && strobe.load[2]) |=> capQ[2] == $past(window[2*DATA_W-1:DATA_W]));
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
  import dual_cap_pkg::*;
#(
  parameter int TB_W    = 24,
  parameter int DATA_W  = 8,
  parameter int SHIFT_W = 3,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        capIn,
  input  logic [TB_W-1:0]   timeBase,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int CFG_W = SHIFT_W + 2;

  capStrobe_t                      strobe;
  logic [SHIFT_W-1:0]              shift;
  logic [CFG_W-1:0]                cfgQ;
  logic [3:0]                      ienQ, statusQ;
  logic [SLOT_NUM-1:0][DATA_W-1:0] capQ;
  logic [1:0]                      capIdx;

  dual_cap_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .capIn(capIn), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .wrData(wrData), .strobe(strobe), .shift(shift),
    .cfgQ(cfgQ), .ienQ(ienQ), .statusQ(statusQ), .irq(irq)
  );

  dual_cap_data #(.TB_W(TB_W), .DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_data (
    .clk(clk), .rstN(rstN), .timeBase(timeBase), .strobe(strobe),
    .shift(shift), .capQ(capQ)
  );

  assign capIdx = 2'(regSel - ADDR_W'(A_CAP0));

  always_comb begin
    rdData = '0;
    if (regSel == ADDR_W'(A_CFG))       rdData = DATA_W'(cfgQ);
    else if (regSel == ADDR_W'(A_IEN))  rdData = DATA_W'(ienQ);
    else if (regSel == ADDR_W'(A_STAT)) rdData = DATA_W'(statusQ);
    else if (regSel >= ADDR_W'(A_CAP0)) rdData = capQ[capIdx];
  end
endmodule

// File: tb/dual_edge_capture_bench.sv
module dual_edge_capture_bench;
  localparam int INC = 37;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  capIn = 2'b00;
  logic [23:0] tb;
  logic [2:0]  regSel = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        irq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  logic [7:0] expReg [4];
  logic [3:0] heldM;
  logic [3:0] expStat;
  logic [3:0] ienM;
  logic       wideM, holdM;
  int         sh;

  dual_edge_capture u_dual_edge_capture (
    .clk(clk), .rstN(rstN), .capIn(capIn), .timeBase(tb), .regSel(regSel),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rstN) tb <= 24'h05A3C1;
    else       tb <= tb + 24'(INC);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [7:0] d);
    regSel = 3'(addr); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input int addr, output logic [7:0] d);
    regSel = 3'(addr); rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic putSlot(input int s, input logic [7:0] v);
    if (!holdM || !heldM[s]) begin
      expReg[s] = v;
      if (holdM) heldM[s] = 1'b1;
    end
  endtask

  task automatic edgeEvt(input int ch, input logic lvl);
    logic [23:0] win;
    int s;
    capIn[ch] = lvl;
    win = (tb + 24'(2 * INC)) >> sh;
    s = lvl ? 0 : 1;
    if (!wideM) begin
      putSlot(ch * 2 + s, win[7:0]);
      expStat[ch * 2 + s] = 1'b1;
    end else if (ch == 0) begin
      putSlot(s, win[7:0]);
      putSlot(s + 2, win[15:8]);
      expStat[s] = 1'b1;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkRegs();
    logic [7:0] d;
    string tag;
    for (int j = 0; j < 4; j++) begin
      busRead(4 + j, d);
      if (wideM)      tag = "R5";
      else if (holdM) tag = "R6";
      else if (sh != 0) tag = "R4";
      else if (j % 2 == 0) tag = "R2";
      else tag = "R3";
      chk($sformatf("%s slot%0d sh%0d", tag, j, sh), d, expReg[j]);
      if (!wideM) heldM[j] = 1'b0;
      else if (j < 2) begin heldM[j] = 1'b0; heldM[j + 2] = 1'b0; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int j = 0; j < 4; j++) expReg[j] = 8'h00;
    heldM = '0; expStat = '0; ienM = '0; wideM = 0; holdM = 0; sh = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      busRead(a, d);
      chk($sformatf("R1 addr%0d", a), d, 8'h00);
    end
    chk("R1 irq", irq, 1'b0);

    for (int s = 0; s < 8; s++) begin
      for (int md = 0; md < 4; md++) begin
        sh = s; wideM = md[0]; holdM = md[1];
        busWrite(0, {3'b000, 3'(s), holdM, wideM});
        if (!holdM) heldM = '0;
        busRead(0, d);
        chk("R10 cfg readback", d, {3'b000, 3'(s), holdM, wideM});
        busWrite(2, 8'h0F);
        expStat = '0;
        ienM = 4'(s * 3 + md + 1);
        busWrite(1, {4'h0, ienM});
        edgeEvt(0, 1); edgeEvt(1, 1); edgeEvt(0, 0); edgeEvt(1, 0);
        edgeEvt(0, 1); edgeEvt(1, 1);
        checkRegs();
        edgeEvt(0, 0); edgeEvt(0, 1);
        checkRegs();
        busRead(2, d);
        chk("R7 status", d, {4'h0, expStat});
        chk("R9 irq", irq, |(expStat & ienM));
        edgeEvt(1, 0); edgeEvt(0, 0);
        checkRegs();
      end
    end

    // R9: masking all enables drops irq while status stays
    busWrite(0, 8'h00); wideM = 0; holdM = 0; sh = 0; heldM = '0;
    busWrite(2, 8'h0F); expStat = '0;
    busWrite(1, 8'h08);
    edgeEvt(1, 1); edgeEvt(1, 0);
    chk("R9 irq enabled fall", irq, 1'b1);
    busWrite(1, 8'h00);
    chk("R9 irq masked", irq, 1'b0);

    // R8: write zero leaves status, write one clears
    busWrite(2, 8'h00);
    busRead(2, d);
    chk("R8 zero write", d, 8'h0C);
    busWrite(2, 8'h04);
    busRead(2, d);
    chk("R8 one clears", d, 8'h08);

    // R8: clear in the same cycle as a channel 0 rise event keeps the bit
    capIn[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busWrite(2, 8'h09);
    repeat (3) @(negedge clk);
    busRead(2, d);
    chk("R8 set beats clear", d, 8'h01);

    // R10: unused address
    busRead(3, d);
    chk("R10 unused", d, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule